// File: doc/BRIEF.md
# Jitter Absorbing Frame Buffer Controller

This block controls the addressing of a small frame store placed between a disc demodulator and the downstream decoder. Demodulated symbols arrive in step with the recovered playback clock and are written frame by frame. They are read back frame by frame on the crystal reference clock. The store holds a window of frames on either side of the nominal fill point, so speed wobble of the disc changes only how far the writer runs ahead of the reader. The audio timing stays fixed.

The read domain follows the writer's frame position and reports the signed frame lead against the centre to the spindle servo as a phase error. When the lead leaves the allowed window in either direction, the write position is pulled back to the centre and the output is muted for a fixed number of frame periods. Nothing in the data path can flag the frames that are lost or repeated. The mute is also active out of reset until the first mute period has run out.

Top module: `fbuf_ctrl`

## Requirements
- R1: After reset, `phase_err_o` reads 0, `mute_o` is 1 and `recenter_o` is 0. The first frame written lands `WIN` frames ahead of the first frame read.
- R2: Each cycle with `wr_en_i` high stores `wr_data_i` at the next symbol of the current write frame. `SYMS` symbols form one frame. The write frame slot advances modulo `2*WIN+1`.
- R3: Each cycle with `rd_en_i` high presents, on `rd_data_o` in the following cycle, the symbol at the next position of the current read frame. Frames are read in the order they were written.
- R4: `phase_err_o` is the two's-complement count (`CW` bits, positive while the writer is ahead) of frames written minus frames read since reset or since the last recentering. It follows a completed write frame within a few read clock cycles and changes by at most one per read cycle outside a recentering.
- R5: When `phase_err_o` reaches `WIN+1`, `recenter_o` pulses for exactly one read cycle. The write position is then forced to the centre, so `phase_err_o` settles to 0 and the next written frame is the one read `WIN` frames after the next frame to be read.
- R6: When `phase_err_o` reaches `-(WIN+1)`, the same single pulse and recentering to 0 take place.
- R7: Out of reset, `mute_o` stays high until `MUTE_FRAMES` read frames have completed. It falls only at the end of a read frame.
- R8: A recentering asserts `mute_o` in the same cycle as `recenter_o`. It holds `mute_o` for `MUTE_FRAMES` further completed read frames.
- R9: A recentering while `mute_o` is already high restarts the full `MUTE_FRAMES` count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Recovered playback clock, write domain |
| rd_clk_i | input | 1 | Crystal reference clock, read domain |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Store one symbol this write cycle |
| wr_data_i | input | DW | Symbol to store |
| rd_en_i | input | 1 | Fetch one symbol this read cycle |
| rd_data_o | output | DW | Fetched symbol, one read cycle after `rd_en_i` |
| phase_err_o | output | CW | Signed frame lead of writer against centre, to spindle control |
| mute_o | output | 1 | Mute request to the audio output |
| recenter_o | output | 1 | One-cycle pulse when the window was left and the writer recentred |

## Verification
The bench builds the block with `SYMS=4` and keeps `WIN=4`, `CW=6` and `MUTE_FRAMES=128`. The short frames let the full reset mute, two back-to-back mute periods and the restart inside one of them run many times over within the cycle budget. The frame slots wrap modulo 9 dozens of times, so stale-slot reuse is visible. The two clocks run at 10 and 14 units, so the Gray-coded crossing and the recentering handshake are tested at unrelated phases. Both window edges, `+5` and `-5`, are driven deliberately, and random traffic stays strictly inside them.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  localparam int GW = 16;

  function automatic logic [GW-1:0] gray_enc(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GW-1:0] gray_dec(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/fbuf_sync.sv
module fbuf_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/fbuf_wr_ctrl.sv
module fbuf_wr_ctrl
  import fbuf_pkg::*;
#(
  parameter int SYMS  = 32,
  parameter int SLOTS = 9,
  parameter int WIN   = 4,
  parameter int CW    = 6,
  parameter int AW    = 9,
  parameter int SW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          req_i,
  input  logic [CW-1:0] tgt_cnt_i,
  input  logic [SW-1:0] tgt_slot_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [CW-1:0] wr_gray_o,
  output logic          ack_o
);
  localparam int SYMW = (SYMS > 1) ? $clog2(SYMS) : 1;

  logic [SYMW-1:0] sym_q, sym_d;
  logic [SW-1:0]   slot_q, slot_d;
  logic [CW-1:0]   cnt_q, cnt_d, gray_q;
  logic            ack_q, load;

  // a toggled request carries a recentering order from the read side
  assign load = req_i != ack_q;

  always_comb begin
    sym_d  = sym_q;
    slot_d = slot_q;
    cnt_d  = cnt_q;
    if (load) begin
      sym_d  = '0;
      slot_d = tgt_slot_i;
      cnt_d  = tgt_cnt_i;
    end else if (wr_en_i) begin
      if (sym_q == SYMW'(SYMS - 1)) begin
        sym_d  = '0;
        cnt_d  = cnt_q + CW'(1);
        slot_d = (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + SW'(1);
      end else begin
        sym_d = sym_q + SYMW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q  <= '0;
      slot_q <= SW'(WIN);
      cnt_q  <= CW'(WIN);
      gray_q <= CW'(gray_enc(GW'(WIN)));
      ack_q  <= 1'b0;
    end else begin
      sym_q  <= sym_d;
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
      gray_q <= CW'(gray_enc(GW'(cnt_d)));
      ack_q  <= req_i;
    end
  end

  assign wr_addr_o = AW'(slot_q) * AW'(SYMS) + AW'(sym_q);
  assign wr_gray_o = gray_q;
  assign ack_o     = ack_q;
endmodule

// File: rtl/fbuf_rd_ctrl.sv
module fbuf_rd_ctrl
  import fbuf_pkg::*;
#(
  parameter int SYMS        = 32,
  parameter int SLOTS       = 9,
  parameter int WIN         = 4,
  parameter int CW          = 6,
  parameter int MUTE_FRAMES = 128,
  parameter int AW          = 9,
  parameter int SW          = 4,
  parameter int MW          = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [CW-1:0] wr_gray_i,
  input  logic          ack_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [CW-1:0] phase_err_o,
  output logic          mute_o,
  output logic          recenter_o,
  output logic          req_o,
  output logic [CW-1:0] tgt_cnt_o,
  output logic [SW-1:0] tgt_slot_o,
  output logic          busy_o
);
  localparam int SYMW = (SYMS > 1) ? $clog2(SYMS) : 1;
  localparam logic signed [CW-1:0] WIN_P = CW'(WIN);
  localparam logic signed [CW-1:0] WIN_N = -CW'(WIN);

  logic [SYMW-1:0] sym_q;
  logic [SW-1:0]   slot_q, slot_nxt, tgt_slot_q;
  logic [CW-1:0]   cnt_q, cnt_nxt, wr_bin, dev, tgt_cnt_q;
  logic [MW-1:0]   mute_q;
  logic [1:0]      settle_q;
  logic            ack_q, req_q, recenter_q, frame_end, busy, ovf;

  assign frame_end = rd_en_i && (sym_q == SYMW'(SYMS - 1));

  always_comb begin
    slot_nxt = slot_q;
    cnt_nxt  = cnt_q;
    if (frame_end) begin
      cnt_nxt  = cnt_q + CW'(1);
      slot_nxt = (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + SW'(1);
    end
  end

  // lead of writer over reader, minus the nominal centre lead
  assign wr_bin = CW'(gray_dec(GW'(wr_gray_i)));
  assign dev    = wr_bin - cnt_q - CW'(WIN);

  // window check is blind while an order is in flight and briefly after
  assign busy = (req_q != ack_i) || (settle_q != 2'd0);
  assign ovf  = !busy && (($signed(dev) > WIN_P) || ($signed(dev) < WIN_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q      <= '0;
      slot_q     <= '0;
      cnt_q      <= '0;
      ack_q      <= 1'b0;
      settle_q   <= 2'd0;
      req_q      <= 1'b0;
      tgt_cnt_q  <= CW'(WIN);
      tgt_slot_q <= SW'(WIN);
      recenter_q <= 1'b0;
      mute_q     <= MW'(MUTE_FRAMES);
    end else begin
      if (rd_en_i) sym_q <= frame_end ? '0 : sym_q + SYMW'(1);
      slot_q <= slot_nxt;
      cnt_q  <= cnt_nxt;

      ack_q <= ack_i;
      if (ack_i != ack_q)      settle_q <= 2'd2;
      else if (settle_q != 0)  settle_q <= settle_q - 2'd1;

      recenter_q <= ovf;
      if (ovf) begin
        req_q      <= ~req_q;
        tgt_cnt_q  <= cnt_nxt + CW'(WIN);
        tgt_slot_q <= (slot_nxt >= SW'(SLOTS - WIN)) ? slot_nxt - SW'(SLOTS - WIN)
                                                     : slot_nxt + SW'(WIN);
      end

      if (ovf)                             mute_q <= MW'(MUTE_FRAMES);
      else if (frame_end && mute_q != '0)  mute_q <= mute_q - MW'(1);
    end
  end

  assign rd_addr_o   = AW'(slot_q) * AW'(SYMS) + AW'(sym_q);
  assign phase_err_o = dev;
  assign mute_o      = mute_q != '0;
  assign recenter_o  = recenter_q;
  assign req_o       = req_q;
  assign tgt_cnt_o   = tgt_cnt_q;
  assign tgt_slot_o  = tgt_slot_q;
  assign busy_o      = busy;
endmodule

// File: rtl/fbuf_ctrl.sv
module fbuf_ctrl
  import fbuf_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYMS        = 32,
  parameter int WIN         = 4,
  parameter int CW          = 6,
  parameter int MUTE_FRAMES = 128
) (
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] phase_err_o,
  output logic          mute_o,
  output logic          recenter_o
);
  localparam int SLOTS = 2 * WIN + 1;
  localparam int DEPTH = SLOTS * SYMS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SW    = $clog2(SLOTS);
  localparam int MW    = $clog2(MUTE_FRAMES + 1);
  localparam logic [CW-1:0] GRAY_RST = CW'(gray_enc(GW'(WIN)));

  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] wr_gray, wr_gray_rd, tgt_cnt;
  logic [SW-1:0] tgt_slot;
  logic          req, req_wr, ack, ack_rd, rd_busy;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_data_q;

  fbuf_wr_ctrl #(
    .SYMS(SYMS), .SLOTS(SLOTS), .WIN(WIN), .CW(CW), .AW(AW), .SW(SW)
  ) wr_ctrl_i (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .req_i(req_wr),
    .tgt_cnt_i(tgt_cnt), .tgt_slot_i(tgt_slot), .wr_addr_o(wr_addr),
    .wr_gray_o(wr_gray), .ack_o(ack)
  );

  fbuf_sync #(.W(CW), .RST_VAL(GRAY_RST)) gray_sync_i (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .d_i(wr_gray), .q_o(wr_gray_rd)
  );

  fbuf_sync #(.W(1), .RST_VAL(1'b0)) req_sync_i (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .d_i(req), .q_o(req_wr)
  );

  fbuf_sync #(.W(1), .RST_VAL(1'b0)) ack_sync_i (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .d_i(ack), .q_o(ack_rd)
  );

  fbuf_rd_ctrl #(
    .SYMS(SYMS), .SLOTS(SLOTS), .WIN(WIN), .CW(CW), .MUTE_FRAMES(MUTE_FRAMES),
    .AW(AW), .SW(SW), .MW(MW)
  ) rd_ctrl_i (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .wr_gray_i(wr_gray_rd),
    .ack_i(ack_rd), .rd_addr_o(rd_addr), .phase_err_o(phase_err_o),
    .mute_o(mute_o), .recenter_o(recenter_o), .req_o(req),
    .tgt_cnt_o(tgt_cnt), .tgt_slot_o(tgt_slot), .busy_o(rd_busy)
  );

  always_ff @(posedge wr_clk_i) begin
    if (wr_en_i) mem[wr_addr] <= wr_data_i;
  end

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= mem[rd_addr];
  end

  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/fbuf_ctrl_chk.sv
module fbuf_ctrl_chk #(
  parameter int WIN = 4,
  parameter int CW  = 6
) (
  input logic          rd_clk_i,
  input logic          rst_ni,
  input logic          rd_en_i,
  input logic [CW-1:0] phase_err_o,
  input logic          mute_o,
  input logic          recenter_o,
  input logic          busy_i
);
  logic [CW-1:0] pe_prev, pe_delta;
  logic          busy_prev;

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pe_prev   <= '0;
      busy_prev <= 1'b0;
    end else begin
      pe_prev   <= phase_err_o;
      busy_prev <= busy_i;
    end
  end

  assign pe_delta = phase_err_o - pe_prev;

  // R5
  recenter_pulse_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    recenter_o |=> !recenter_o);

  // R8
  recenter_mute_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    recenter_o |-> mute_o);

  // R6
  recenter_cause_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    recenter_o |-> ($signed($past(phase_err_o)) > $signed(CW'(WIN)) ||
                    $signed($past(phase_err_o)) < -$signed(CW'(WIN))));

  // R4
  phase_step_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (!busy_i && !busy_prev) |->
      (pe_delta == '0 || pe_delta == CW'(1) || pe_delta == {CW{1'b1}}));

  // R7
  mute_release_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $fell(mute_o) |-> $past(rd_en_i));
endmodule

bind fbuf_ctrl fbuf_ctrl_chk #(.WIN(WIN), .CW(CW)) chk_i (
  .rd_clk_i(rd_clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i),
  .phase_err_o(phase_err_o), .mute_o(mute_o), .recenter_o(recenter_o),
  .busy_i(rd_busy)
);

// File: tb/fbuf_ctrl_tb_top.sv
module fbuf_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WR_HALF    = 7;
  localparam int DW = 8, SYMS = 4, WIN = 4, CW = 6, MUTE = 128;
  localparam int SEED = 32'h5eed1;

  logic rd_clk = 1'b0, wr_clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] phase_err;
  logic mute, recenter;

  always #(CLK_PERIOD / 2) rd_clk = ~rd_clk;
  always #(WR_HALF) wr_clk = ~wr_clk;

  fbuf_ctrl #(.DW(DW), .SYMS(SYMS), .WIN(WIN), .CW(CW), .MUTE_FRAMES(MUTE)) dut_i (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .phase_err_o(phase_err), .mute_o(mute), .recenter_o(recenter)
  );

  int n_chk = 0, n_fail = 0;
  int pe = 0, wf = WIN, rf = 0, valid_lo = WIN, mute_left = MUTE;
  int rc_seen = 0, rc_exp = 0;
  bit done = 0;

  always @(negedge rd_clk) if (rst_n && recenter) rc_seen++;

  function automatic logic [DW-1:0] pat(int f, int s);
    return DW'(f * 37 + s * 5 + 27);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic write_frame();
    for (int s = 0; s < SYMS; s++) begin
      @(negedge wr_clk);
      wr_en = 1'b1;
      wr_data = pat(wf, s);
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
    wf++;
    pe++;
  endtask

  task automatic read_frame();
    for (int s = 0; s <= SYMS; s++) begin
      @(negedge rd_clk);
      if (s > 0 && rf >= valid_lo && rf < wf)
        check(rd_data == pat(rf, s - 1), "R2 R3 data", int'(rd_data), int'(pat(rf, s - 1)));
      rd_en = (s < SYMS);
    end
    rf++;
    pe--;
    if (mute_left > 0) mute_left--;
  endtask

  task automatic check_state(string tag);
    check(int'($signed(phase_err)) == pe, {tag, " R4 phase"}, int'($signed(phase_err)), pe);
    check(mute == (mute_left != 0), {tag, " R7 R8 R9 mute"}, int'(mute), int'(mute_left != 0));
    check(rc_seen == rc_exp, {tag, " R5 R6 recenter count"}, rc_seen, rc_exp);
  endtask

  task automatic recentered();
    rc_exp++;
    pe = 0;
    wf = rf + WIN;
    valid_lo = wf;
    mute_left = MUTE;
  endtask

  initial begin
    repeat (100000) @(posedge rd_clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(SEED);
    repeat (3) @(negedge rd_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge rd_clk);

    // R1: reset state
    check(phase_err == '0, "R1 phase", int'(phase_err), 0);
    check(mute == 1'b1, "R1 mute", int'(mute), 1);
    check(recenter == 1'b0, "R1 recenter", int'(recenter), 0);

    // R4: directed lead changes
    write_frame(); write_frame();
    repeat (8) @(negedge rd_clk);
    check_state("R4 +2");
    read_frame(); read_frame(); read_frame();
    repeat (8) @(negedge rd_clk);
    check_state("R4 -1");

    // random traffic inside the window, covers R7 release
    for (int i = 0; i < 400; i++) begin
      bit do_wr;
      do_wr = ($urandom % 2) == 0;
      if (pe >= WIN) do_wr = 0;
      if (pe <= -(WIN - 1)) do_wr = 1;
      if (do_wr) write_frame(); else read_frame();
      repeat (8) @(negedge rd_clk);
      check_state("rand");
    end

    // R5 overflow, R8 mute
    while (pe < WIN + 1) write_frame();
    repeat (40) @(negedge rd_clk);
    recentered();
    check_state("R5 overflow");

    for (int i = 0; i < 60; i++) begin
      write_frame(); read_frame();
      repeat (6) @(negedge rd_clk);
      check_state("R8 pair");
    end

    // R9 restart during mute
    while (pe < WIN + 1) write_frame();
    repeat (40) @(negedge rd_clk);
    recentered();
    check_state("R9 restart");
    for (int i = 0; i < MUTE; i++) begin
      write_frame(); read_frame();
      repeat (6) @(negedge rd_clk);
      check_state("R9 pair");
    end
    check(mute == 1'b0, "R9 mute end", int'(mute), 0);

    // R6 underflow
    while (pe > -(WIN + 1)) read_frame();
    repeat (40) @(negedge rd_clk);
    recentered();
    check_state("R6 underflow");
    for (int i = 0; i < 12; i++) begin
      write_frame(); read_frame();
      repeat (6) @(negedge rd_clk);
      check_state("R6 after");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule